// File: doc/BRIEF.md
# Parallel ADC conversion sequencer

This block sits on the host side of a 12-bit successive-approximation converter that has a parallel result bus. It drives the converter's active-low select line and its convert/read line (low means convert, high means read). It watches the converter's busy line and returns each result as a signed sample with a one-cycle valid strobe. A conversion can be asked for with a start pulse, or it can come from an internal rate timer. Every request is queued, so none is lost. A minimum spacing between conversion starts is enforced. Every timing value is a parameter counted in system-clock cycles.

A normal sequence runs as follows. The convert line is lowered first, so that select is the line that triggers the conversion. Both lines stay low for the convert pulse, and then both return high. Select stays high while the converter works, which keeps the data bus quiet. The block waits for the synchronized busy line to fall and then to rise. The rising edge of busy means the result registers are loaded. The block then enters read mode (select low, convert high) for the bus access time and captures the word at the end of that window. A parameter selects a wiring in which select is tied low. In that mode only the convert line moves. If busy never falls, or never returns high, a timeout sets a sticky error flag and the sequencer returns to idle.

Top module: `adc_conv_seq`

## Requirements
- R1: With select not tied, each conversion begins with adc_conv_n falling while adc_sel_n is high. adc_sel_n then falls SETUP_CYC cycles later, so select is the triggering line.
- R2: adc_sel_n and adc_conv_n are both low for exactly PULSE_CYC consecutive cycles per conversion, after which adc_conv_n returns high.
- R3: adc_busy passes through a two-flop synchronizer. Once the synchronized busy has been seen low and then high, read mode (adc_sel_n low, adc_conv_n high) is held for ACCESS_CYC cycles. sample_vld is then high for one cycle, and sample holds adc_data as it was in the last read cycle.
- R4: With select not tied, adc_sel_n stays high from the end of the convert pulse until busy has been seen high again.
- R5: Conversion starts are at least SPACING_CYC cycles apart. A request that has been held back starts exactly SPACING_CYC cycles after the previous start.
- R6: Every cycle with start_req high, and every rate tick, produces one conversion. Up to 2^PEND_W-1 requests are held.
- R7: While rate_en is high, a rate tick occurs every RATE_CYC cycles, the first one RATE_CYC cycles after rate_en rises. rate_en low clears the timer.
- R8: If the synchronized busy is not low within FALL_TO_CYC cycles after the convert pulse ends, err is set, the sequencer returns to idle, and no sample_vld is produced.
- R9: If the synchronized busy, once low, does not return high within RISE_TO_CYC cycles, err is set, the sequencer returns to idle, and no sample_vld is produced.
- R10: With SEL_TIED set, adc_sel_n is constantly low. A conversion is then a PULSE_CYC-cycle low on adc_conv_n with no setup phase.
- R11: After reset adc_sel_n is high (or low when tied), adc_conv_n is high, and sample_vld and err are 0. err stays set until the next reset.
- R12: sample is the two's-complement reading of the 12-bit word: 12'h7FF gives 2047, 12'h800 gives -2048, and 12'hFFF gives -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One request per cycle high |
| rate_en | input | 1 | Enables the periodic request timer |
| adc_busy | input | 1 | Converter busy, low while converting |
| adc_data | input | DATA_W | Converter parallel result bus |
| adc_sel_n | output | 1 | Active-low converter select |
| adc_conv_n | output | 1 | Low = convert, high = read |
| sample | output | DATA_W | Signed captured result |
| sample_vld | output | 1 | One-cycle strobe for sample |
| err | output | 1 | Sticky busy-timeout flag |

## Verification
The bench sends a burst of back-to-back requests. If the design merged them, fewer samples would come out. If it launched them on arrival, the measured start gap would be shorter than the spacing. Each start is checked for select-last ordering and for an exact pulse length, so a design that dropped the setup phase or miscounted the pulse would show a wrong edge order or run length. Results with the sign bit set check the signed mapping. Two stuck-busy cases, one that never falls and one that never rises, check that the error is sticky and that no stale sample is reported. The tied-select build runs alongside the normal build and is compared every cycle against a behavioural model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_WFALL,
    ST_WRISE,
    ST_READ
  } seq_st_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles between launch decision and the convert pulse
  function automatic int lead_cycles(input bit tied, input int setup);
    return tied ? 0 : setup;
  endfunction

  // spacing count at which a queued launch may be issued
  function automatic int launch_threshold(input int spacing, input int lead);
    return spacing - lead - 1;
  endfunction

endpackage

// File: rtl/seq_rate_gen.sv
module seq_rate_gen #(
  parameter int RATE_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int RW = $clog2(RATE_CYC + 1);
  localparam logic [RW-1:0] LAST = RW'(RATE_CYC - 1);

  logic [RW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  generate
    if (RATE_CYC > 1) begin : g_gap_chk
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R7
    end
  endgenerate

endmodule

// File: rtl/seq_req_gate.sv
module seq_req_gate #(
  parameter int PEND_W      = 4,
  parameter int SPACING_CYC = 125,
  parameter int THRESH      = 123
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic tick,
  input  logic is_idle,
  input  logic conv_start,
  output logic launch
);
  localparam int SW = $clog2(SPACING_CYC + 1);
  localparam int AW = PEND_W + 2;
  localparam logic [SW-1:0] SP_MAX = SW'(SPACING_CYC);
  localparam logic [SW-1:0] SP_THR = SW'(THRESH);
  localparam logic [AW-1:0] P_MAX  = AW'((1 << PEND_W) - 1);

  logic [PEND_W-1:0] pend;
  logic [SW-1:0]     sp;
  logic [AW-1:0]     sum;

  assign launch = is_idle && (pend != '0) && (sp >= SP_THR);
  assign sum    = AW'(pend) + AW'(req) + AW'(tick) - AW'(launch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      sp   <= SP_MAX;
    end else begin
      pend <= (sum > P_MAX) ? P_MAX[PEND_W-1:0] : sum[PEND_W-1:0];
      if (conv_start)       sp <= '0;
      else if (sp < SP_MAX) sp <= sp + 1'b1;
    end
  end

  AST_PEND_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !launch && pend != '1) |=> pend != '0); // R6

endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter bit SEL_TIED    = 1'b0,
  parameter int SETUP_CYC   = 1,
  parameter int PULSE_CYC   = 4,
  parameter int ACCESS_CYC  = 7,
  parameter int FALL_TO_CYC = 15,
  parameter int RISE_TO_CYC = 120
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     launch,
  input  logic                     adc_busy,
  input  logic [DATA_W-1:0]        adc_data,
  output logic                     adc_sel_n,
  output logic                     adc_conv_n,
  output logic signed [DATA_W-1:0] sample,
  output logic                     sample_vld,
  output logic                     err,
  output logic                     is_idle,
  output logic                     conv_start,
  output logic                     busy_q
);
  localparam int MAXC = max_of(max_of(SETUP_CYC, PULSE_CYC),
                               max_of(ACCESS_CYC, max_of(FALL_TO_CYC, RISE_TO_CYC)));
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LIM = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_LIM = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] ACC_LIM   = CW'(ACCESS_CYC - 1);
  localparam logic [CW-1:0] FTO_LIM   = CW'(FALL_TO_CYC - 1);
  localparam logic [CW-1:0] RTO_LIM   = CW'(RISE_TO_CYC - 1);

  seq_st_e        st, st_n;
  logic [CW-1:0]  cnt;
  logic           busy_m;
  logic           to_err, done;

  // two-flop synchronizer for the converter busy line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= 1'b1;
      busy_q <= 1'b1;
    end else begin
      busy_m <= adc_busy;
      busy_q <= busy_m;
    end
  end

  always_comb begin
    st_n   = st;
    to_err = 1'b0;
    done   = 1'b0;
    unique case (st)
      ST_IDLE:  if (launch) st_n = SEL_TIED ? ST_PULSE : ST_SETUP;
      ST_SETUP: if (cnt == SETUP_LIM) st_n = ST_PULSE;
      ST_PULSE: if (cnt == PULSE_LIM) st_n = ST_WFALL;
      ST_WFALL: begin
        if (!busy_q) st_n = ST_WRISE;
        else if (cnt == FTO_LIM) begin st_n = ST_IDLE; to_err = 1'b1; end
      end
      ST_WRISE: begin
        if (busy_q) st_n = ST_READ;
        else if (cnt == RTO_LIM) begin st_n = ST_IDLE; to_err = 1'b1; end
      end
      ST_READ:  if (cnt == ACC_LIM) begin st_n = ST_IDLE; done = 1'b1; end
      default:  st_n = ST_IDLE;
    endcase
  end

  assign conv_start = (st_n == ST_PULSE) && (st != ST_PULSE);
  assign is_idle    = (st == ST_IDLE);
  assign adc_sel_n  = SEL_TIED ? 1'b0 : !((st == ST_PULSE) || (st == ST_READ));
  assign adc_conv_n = !((st == ST_SETUP) || (st == ST_PULSE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      err        <= 1'b0;
      sample     <= '0;
      sample_vld <= 1'b0;
    end else begin
      st         <= st_n;
      cnt        <= ((st_n != st) || (st == ST_IDLE)) ? '0 : cnt + 1'b1;
      sample_vld <= done;
      if (to_err) err <= 1'b1;
      if (done)   sample <= $signed(adc_data);
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> !sample_vld); // R3
  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (is_idle && !sample_vld)); // R9

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter bit SEL_TIED    = 1'b0,
  parameter int SETUP_CYC   = 1,
  parameter int PULSE_CYC   = 4,
  parameter int ACCESS_CYC  = 7,
  parameter int SPACING_CYC = 125,
  parameter int FALL_TO_CYC = 15,
  parameter int RISE_TO_CYC = 120,
  parameter int RATE_CYC    = 200,
  parameter int PEND_W      = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_req,
  input  logic                     rate_en,
  input  logic                     adc_busy,
  input  logic [DATA_W-1:0]        adc_data,
  output logic                     adc_sel_n,
  output logic                     adc_conv_n,
  output logic signed [DATA_W-1:0] sample,
  output logic                     sample_vld,
  output logic                     err
);
  localparam int LEAD   = lead_cycles(SEL_TIED, SETUP_CYC);
  localparam int THRESH = launch_threshold(SPACING_CYC, LEAD);

  logic tick, launch, is_idle, conv_start, busy_q;

  seq_rate_gen #(.RATE_CYC(RATE_CYC)) u_rate (
    .clk(clk), .rst_n(rst_n), .en(rate_en), .tick(tick)
  );

  seq_req_gate #(.PEND_W(PEND_W), .SPACING_CYC(SPACING_CYC), .THRESH(THRESH)) u_gate (
    .clk(clk), .rst_n(rst_n), .req(start_req), .tick(tick),
    .is_idle(is_idle), .conv_start(conv_start), .launch(launch)
  );

  seq_ctrl_fsm #(
    .DATA_W(DATA_W), .SEL_TIED(SEL_TIED), .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC), .ACCESS_CYC(ACCESS_CYC),
    .FALL_TO_CYC(FALL_TO_CYC), .RISE_TO_CYC(RISE_TO_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .launch(launch), .adc_busy(adc_busy),
    .adc_data(adc_data), .adc_sel_n(adc_sel_n), .adc_conv_n(adc_conv_n),
    .sample(sample), .sample_vld(sample_vld), .err(err),
    .is_idle(is_idle), .conv_start(conv_start), .busy_q(busy_q)
  );

  // port-level observation of conversion starts for the checks below
  localparam int GW = $clog2(SPACING_CYC + 1);
  localparam int PW = $clog2(PULSE_CYC + 2);
  localparam logic [GW-1:0] GAP_MAX = GW'(SPACING_CYC);
  localparam logic [PW-1:0] RUN_MAX = PW'(PULSE_CYC + 1);
  localparam logic [PW-1:0] RUN_EXP = PW'(PULSE_CYC);

  logic both_low, prev_both, port_start;
  logic [GW-1:0] gap;
  logic [PW-1:0] run;

  assign both_low   = !adc_sel_n && !adc_conv_n;
  assign port_start = both_low && !prev_both;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_both <= 1'b0;
      gap       <= GAP_MAX;
      run       <= '0;
    end else begin
      prev_both <= both_low;
      if (port_start)         gap <= GW'(1);
      else if (gap < GAP_MAX) gap <= gap + 1'b1;
      if (!both_low)          run <= '0;
      else if (run < RUN_MAX) run <= run + 1'b1;
    end
  end

  AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    port_start |-> (gap >= GAP_MAX)); // R5
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_both && !both_low) |-> (run == RUN_EXP)); // R2
  AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!SEL_TIED && $fell(adc_sel_n) && adc_conv_n) |-> busy_q); // R3

  generate
    if (!SEL_TIED) begin : g_sel_chk
      AST_SEL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        port_start |-> ($past(!adc_conv_n) && $past(adc_sel_n))); // R1
      AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_conv_n && !busy_q) |-> adc_sel_n); // R4
    end
  endgenerate

endmodule

// File: tb/adc_conv_seq_bench.sv
module adc_emu #(
  parameter int FALL_DLY = 2,
  parameter int LOW_LEN  = 6
) (
  input  logic        clk,
  input  logic        sel_n,
  input  logic        conv_n,
  input  int          mode,      // 0 normal, 1 busy never falls, 2 busy never rises
  input  logic [11:0] nxt_val,
  output logic        busy,
  output logic [11:0] data
);
  int  phase = 0;
  int  k = 0;
  bit  prevb = 1'b0;
  bit  both;
  initial begin busy = 1'b1; data = '0; end
  always @(negedge clk) begin
    both = !sel_n && !conv_n;
    case (phase)
      0: if (both && !prevb && mode != 1) begin phase = 1; k = FALL_DLY; end
      1: begin
        k = k - 1;
        if (k == 0) begin busy <= 1'b0; phase = 2; k = LOW_LEN; end
      end
      default: begin
        k = k - 1;
        if (k == 0) begin
          if (mode != 2) begin busy <= 1'b1; data <= nxt_val; end
          phase = 0;
        end
      end
    endcase
    prevb = both;
  end
endmodule

module seq_ref #(
  parameter bit SEL_TIED    = 1'b0,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int ACCESS_CYC  = 2,
  parameter int SPACING_CYC = 40,
  parameter int FALL_TO_CYC = 8,
  parameter int RISE_TO_CYC = 20,
  parameter int RATE_CYC    = 50,
  parameter int PEND_MAX    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              rate_en,
  input  logic              adc_busy,
  input  logic [11:0]       adc_data,
  output logic              m_sel_n,
  output logic              m_conv_n,
  output logic signed [11:0] m_sample,
  output logic              m_vld,
  output logic              m_err
);
  // phase: 0 idle, 1 setup, 2 pulse, 3 wait fall, 4 wait rise, 5 read
  integer ph, nph, cnt, pend, sp, rcnt, b1, b2, tick, go, vld, lead;
  always @(posedge clk) begin
    lead = SEL_TIED ? 0 : SETUP_CYC;
    if (!rst_n) begin
      ph = 0; cnt = 0; pend = 0; sp = SPACING_CYC; rcnt = 0; b1 = 1; b2 = 1;
      m_vld <= 1'b0; m_err <= 1'b0; m_sample <= '0;
    end else begin
      tick = (rate_en && rcnt == RATE_CYC - 1) ? 1 : 0;
      if (!rate_en || tick == 1) rcnt = 0; else rcnt = rcnt + 1;
      go = (ph == 0 && pend > 0 && sp >= SPACING_CYC - lead - 1) ? 1 : 0;
      pend = pend + (start_req ? 1 : 0) + tick - go;
      if (pend > PEND_MAX) pend = PEND_MAX;
      nph = ph; vld = 0;
      case (ph)
        0: if (go == 1) nph = SEL_TIED ? 2 : 1;
        1: if (cnt == SETUP_CYC - 1) nph = 2;
        2: if (cnt == PULSE_CYC - 1) nph = 3;
        3: if (b2 == 0) nph = 4;
           else if (cnt == FALL_TO_CYC - 1) begin nph = 0; m_err <= 1'b1; end
        4: if (b2 == 1) nph = 5;
           else if (cnt == RISE_TO_CYC - 1) begin nph = 0; m_err <= 1'b1; end
        default: if (cnt == ACCESS_CYC - 1) begin
          nph = 0; vld = 1; m_sample <= $signed(adc_data);
        end
      endcase
      if (nph == 2 && ph != 2) sp = 0;
      else if (sp < SPACING_CYC) sp = sp + 1;
      if (nph != ph || ph == 0) cnt = 0; else cnt = cnt + 1;
      ph = nph;
      b2 = b1; b1 = adc_busy ? 1 : 0;
      m_vld <= (vld == 1);
    end
    m_sel_n  <= SEL_TIED ? 1'b0 : !(ph == 2 || ph == 5);
    m_conv_n <= !(ph == 1 || ph == 2);
  end
endmodule

module adc_conv_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P_SETUP = 2, P_PULSE = 3, P_ACC = 2, P_SPACE = 40;
  localparam int P_FTO = 8, P_RTO = 20, P_RATE = 50;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, start_req = 1'b0, rate_en = 1'b0;
  int   emu_mode = 0;
  logic [11:0] nxt_val = '0;

  logic busy_a, busy_b, sel_a, sel_b, conv_a, conv_b, vld_a, vld_b, err_a, err_b;
  logic [11:0] data_a, data_b;
  logic signed [11:0] smp_a, smp_b;
  logic msel_a, msel_b, mconv_a, mconv_b, mvld_a, mvld_b, merr_a, merr_b;
  logic signed [11:0] msmp_a, msmp_b;

  adc_emu u_emu_a (.clk(clk), .sel_n(sel_a), .conv_n(conv_a), .mode(emu_mode),
                   .nxt_val(nxt_val), .busy(busy_a), .data(data_a));
  adc_emu u_emu_b (.clk(clk), .sel_n(sel_b), .conv_n(conv_b), .mode(emu_mode),
                   .nxt_val(nxt_val), .busy(busy_b), .data(data_b));

  adc_conv_seq #(.SEL_TIED(1'b0), .SETUP_CYC(P_SETUP), .PULSE_CYC(P_PULSE),
    .ACCESS_CYC(P_ACC), .SPACING_CYC(P_SPACE), .FALL_TO_CYC(P_FTO),
    .RISE_TO_CYC(P_RTO), .RATE_CYC(P_RATE), .PEND_W(4)) u_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .rate_en(rate_en),
    .adc_busy(busy_a), .adc_data(data_a), .adc_sel_n(sel_a), .adc_conv_n(conv_a),
    .sample(smp_a), .sample_vld(vld_a), .err(err_a));

  adc_conv_seq #(.SEL_TIED(1'b1), .SETUP_CYC(P_SETUP), .PULSE_CYC(P_PULSE),
    .ACCESS_CYC(P_ACC), .SPACING_CYC(P_SPACE), .FALL_TO_CYC(P_FTO),
    .RISE_TO_CYC(P_RTO), .RATE_CYC(P_RATE), .PEND_W(4)) u_adc_conv_seq_tied (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .rate_en(rate_en),
    .adc_busy(busy_b), .adc_data(data_b), .adc_sel_n(sel_b), .adc_conv_n(conv_b),
    .sample(smp_b), .sample_vld(vld_b), .err(err_b));

  seq_ref #(.SEL_TIED(1'b0), .SETUP_CYC(P_SETUP), .PULSE_CYC(P_PULSE),
    .ACCESS_CYC(P_ACC), .SPACING_CYC(P_SPACE), .FALL_TO_CYC(P_FTO),
    .RISE_TO_CYC(P_RTO), .RATE_CYC(P_RATE), .PEND_MAX(15)) u_ref_a (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .rate_en(rate_en),
    .adc_busy(busy_a), .adc_data(data_a), .m_sel_n(msel_a), .m_conv_n(mconv_a),
    .m_sample(msmp_a), .m_vld(mvld_a), .m_err(merr_a));

  seq_ref #(.SEL_TIED(1'b1), .SETUP_CYC(P_SETUP), .PULSE_CYC(P_PULSE),
    .ACCESS_CYC(P_ACC), .SPACING_CYC(P_SPACE), .FALL_TO_CYC(P_FTO),
    .RISE_TO_CYC(P_RTO), .RATE_CYC(P_RATE), .PEND_MAX(15)) u_ref_b (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .rate_en(rate_en),
    .adc_busy(busy_b), .adc_data(data_b), .m_sel_n(msel_b), .m_conv_n(mconv_b),
    .m_sample(msmp_b), .m_vld(mvld_b), .m_err(merr_b));

  int compared = 0, mismatched = 0, cyc = 0;
  int vcnt_a = 0, vcnt_b = 0, run_a = 0;
  int starts[$];
  logic signed [11:0] last_a = '0, last_b = '0;
  bit prev_both_a = 1'b0, prev_sel_a = 1'b1, prev_conv_a = 1'b1, finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // every-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(sel_a == msel_a && conv_a == mconv_a, "R1 lines normal",
          {sel_a, conv_a}, {msel_a, mconv_a});
      chk(vld_a == mvld_a && (!vld_a || smp_a == msmp_a), "R3 sample normal",
          int'(smp_a), int'(msmp_a));
      chk(err_a == merr_a, "R8 err normal", err_a, merr_a);
      chk(sel_b == msel_b && conv_b == mconv_b, "R10 lines tied",
          {sel_b, conv_b}, {msel_b, mconv_b});
      chk(vld_b == mvld_b && (!vld_b || smp_b == msmp_b), "R3 sample tied",
          int'(smp_b), int'(msmp_b));
      chk(err_b == merr_b, "R9 err tied", err_b, merr_b);
    end
  end

  // port monitors on the normal instance: ordering, pulse length, bus quiet
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_both_a = 1'b0; run_a = 0; starts.delete();
    end else begin
      if (!sel_a && !conv_a) begin
        if (!prev_both_a) begin
          chk(!prev_conv_a && prev_sel_a, "R1 select falls last",
              {prev_sel_a, prev_conv_a}, 2'b10);
          starts.push_back(cyc);
        end
        run_a++;
      end else if (prev_both_a) begin
        chk(run_a == P_PULSE, "R2 pulse length", run_a, P_PULSE);
        run_a = 0;
      end
      if (!busy_a && conv_a) chk(sel_a, "R4 select quiet", sel_a, 1);
      if (vld_a) begin vcnt_a++; last_a = smp_a; end
      if (vld_b) begin vcnt_b++; last_b = smp_b; end
      prev_both_a = !sel_a && !conv_a;
    end
    prev_sel_a = sel_a; prev_conv_a = conv_a;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic one_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic conv_value(input logic [11:0] v, input int exp);
    int va, vb;
    va = vcnt_a; vb = vcnt_b;
    nxt_val = v;
    one_start();
    repeat (60) @(negedge clk);
    chk(vcnt_a == va + 1 && int'(last_a) == exp, "R12 signed normal", int'(last_a), exp);
    chk(vcnt_b == vb + 1 && int'(last_b) == exp, "R12 signed tied", int'(last_b), exp);
  endtask

  initial begin
    int va, vb;
    repeat (4) @(negedge clk);
    chk(sel_a == 1'b1 && conv_a == 1'b1, "R11 reset lines", {sel_a, conv_a}, 2'b11);
    chk(!vld_a && !err_a && !vld_b && !err_b, "R11 reset flags",
        {vld_a, err_a, vld_b, err_b}, 0);
    chk(sel_b == 1'b0, "R10 tied select low", sel_b, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    conv_value(12'h7FF, 2047);
    conv_value(12'h800, -2048);
    conv_value(12'hFFF, -1);
    chk(sel_b == 1'b0, "R10 tied select after runs", sel_b, 0);

    // burst: three requests on consecutive cycles
    va = vcnt_a; vb = vcnt_b;
    nxt_val = 12'h123;
    @(negedge clk) start_req = 1'b1;
    repeat (3) @(negedge clk);
    start_req = 1'b0;
    repeat (200) @(negedge clk);
    chk(vcnt_a == va + 3, "R6 burst count normal", vcnt_a - va, 3);
    chk(vcnt_b == vb + 3, "R6 burst count tied", vcnt_b - vb, 3);
    chk(starts[$] - starts[$-1] == P_SPACE, "R5 queued gap",
        starts[$] - starts[$-1], P_SPACE);
    chk(starts[$-1] - starts[$-2] == P_SPACE, "R5 queued gap first",
        starts[$-1] - starts[$-2], P_SPACE);

    // rate timer
    va = vcnt_a;
    rate_en = 1'b1;
    repeat (260) @(negedge clk);
    rate_en = 1'b0;
    repeat (100) @(negedge clk);
    chk(vcnt_a == va + 5, "R7 rate ticks", vcnt_a - va, 5);

    // busy never falls
    va = vcnt_a; vb = vcnt_b;
    emu_mode = 1;
    one_start();
    repeat (60) @(negedge clk);
    chk(err_a && err_b, "R8 fall timeout err", {err_a, err_b}, 2'b11);
    chk(vcnt_a == va && vcnt_b == vb, "R8 no sample", vcnt_a - va, 0);
    repeat (20) @(negedge clk);
    chk(err_a, "R8 err sticky", err_a, 1);

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!err_a && !err_b, "R11 reset clears err", {err_a, err_b}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // busy never rises
    va = vcnt_a; vb = vcnt_b;
    emu_mode = 2;
    one_start();
    repeat (80) @(negedge clk);
    chk(err_a && err_b, "R9 rise timeout err", {err_a, err_b}, 2'b11);
    chk(vcnt_a == va && vcnt_b == vb, "R9 no sample", vcnt_a - va, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule